// File: doc/BRIEF.md
# Saturating ALU with Sticky Overflow Flags

This block is a 32-bit arithmetic unit that clamps its results. Each cycle it takes two operands, an operation code and a mode bit. It computes the exact result at full precision, then clamps it to the 32-bit signed or unsigned range. The result appears combinationally in the same cycle. The unit supports add, subtract and multiply in both signed and unsigned modes. It also supports a bidirectional arithmetic shift with a signed count and an absolute difference, and both of these always use signed semantics.

Four status flags live in registers. Two of them describe the most recent accepted operation: overflow, meaning the result was clamped, and advance-overflow, meaning the two top result bits of the exact value differ. The other two are sticky copies that accumulate those events. An operation is accepted on a clock edge where the valid strobe is high. The sticky copies return to zero only on reset or when the clear input is asserted.

Top module: `sat_alu`

## Requirements
- R1: Operation codes on `op` are add=0, subtract=1, multiply=2, shift=3 and absolute difference=4. With `is_signed`=0, add, subtract and multiply zero-extend both operands, compute the exact value, and clamp it to 0xFFFFFFFF above that value and to 0 below zero.
- R2: With `is_signed`=1, add, subtract and multiply sign-extend both operands, compute the exact value (the full 64-bit product for multiply), and clamp it to 0x7FFFFFFF above and to 0x80000000 below the signed range.
- R3: For shift, the count is `opb[5:0]` read as two's complement (−32 to +31). A positive count shifts `opa` left, a negative count shifts it arithmetically right by the magnitude, and zero passes `opa` unchanged. The upper bits of `opb` and the `is_signed` bit have no effect, and the result is clamped to the signed range.
- R4: Absolute difference treats both operands as signed, takes the larger minus the smaller, and clamps to the signed range. `is_signed` has no effect, so the result is never negative.
- R5: On the clock edge after an accepted operation, `flag_v` is 1 if that operation clamped and 0 if it did not.
- R6: On the clock edge after an accepted operation, `flag_av` equals bit 31 XOR bit 30 of the exact unclamped result.
- R7: On each accepted operation, `flag_sv` ORs in the new overflow and `flag_sav` ORs in the new advance-overflow. No operation clears them. In a cycle with `valid`=0, all four flags hold their values.
- R8: When `clr_sticky`=1, `flag_sv` and `flag_sav` are zero after the edge, except that an operation accepted in the same cycle still sets them from its own events. `flag_v` and `flag_av` are unaffected by the clear.
- R9: With `rst_n` low at a clock edge, all four flags become 0.
- R10: Codes 5 to 7 give result 0 and raise neither overflow nor advance-overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Accept the current operation into the flags |
| op | input | 3 | Operation code |
| is_signed | input | 1 | Signed mode for add, subtract and multiply |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand or shift count |
| clr_sticky | input | 1 | Synchronous clear of the sticky flags |
| result | output | 32 | Clamped result (combinational) |
| flag_v | output | 1 | Overflow of the last accepted operation |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance-overflow of the last accepted operation |
| flag_sav | output | 1 | Sticky advance-overflow |

## Verification
The result path has no state, so a wrong intermediate width or a wrong clamp bound shows on `result` in the same cycle the operands are applied. A wrong flag register shows on the flag ports one edge after the operation. A sticky bit that is set or lost wrongly stays wrong at the ports until the next clear or reset, so it is visible in every later sample. This makes idle cycles and clear cycles between operations the points where a faulty hold or clear priority shows up.

// File: rtl/sat_alu_pkg.sv
// Shared types for the saturating ALU.
// Assumes a 3-bit operation code; codes not listed are treated as no-ops.
package sat_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_MUL    = 3'd2,
        OP_SHA    = 3'd3,
        OP_ABSDIF = 3'd4
    } alu_op_e;
endpackage

// File: rtl/sat_alu_shift.sv
// Bidirectional arithmetic shifter producing an exact wide result.
// The count is a two's complement value: positive counts shift left,
// negative counts shift arithmetically right. The operand is sign-extended.
module sat_alu_shift #(
    parameter int W   = 32,
    parameter int XW  = 2 * W + 1,
    parameter int SHW = $clog2(W) + 1
) (
    input  logic [W-1:0]          val,
    input  logic [SHW-1:0]        cnt,
    output logic signed [XW-1:0]  res
);
    logic signed [XW-1:0] xv;
    logic [SHW-1:0]       mag;

    // Sign-extend the operand and shift by the signed count.
    always_comb begin
        xv  = {{(XW-W){val[W-1]}}, val};
        mag = ~cnt + {{(SHW-1){1'b0}}, 1'b1};
        if (cnt[SHW-1]) begin
            res = xv >>> mag;
        end else begin
            res = xv <<< cnt;
        end
    end
endmodule

// File: rtl/sat_alu_core.sv
// Exact arithmetic stage: forms the full-precision result for each operation
// and selects which range (signed or unsigned) the clamp stage must apply.
// Assumes the shift result is computed outside and handed in.
module sat_alu_core #(
    parameter int W  = 32,
    parameter int XW = 2 * W + 1
) (
    input  logic [2:0]            op,
    input  logic                  is_signed,
    input  logic [W-1:0]          opa,
    input  logic [W-1:0]          opb,
    input  logic signed [XW-1:0]  sh_res,
    output logic signed [XW-1:0]  exact,
    output logic                  sat_signed
);
    import sat_alu_pkg::*;

    logic signed [XW-1:0] xa;
    logic signed [XW-1:0] xb;

    // Extend operands: shift and absolute difference are always signed.
    always_comb begin
        sat_signed = is_signed || (op == OP_SHA) || (op == OP_ABSDIF);
        if (sat_signed) begin
            xa = {{(XW-W){opa[W-1]}}, opa};
            xb = {{(XW-W){opb[W-1]}}, opb};
        end else begin
            xa = {{(XW-W){1'b0}}, opa};
            xb = {{(XW-W){1'b0}}, opb};
        end
    end

    // Select the exact result for the requested operation.
    always_comb begin
        case (alu_op_e'(op))
            OP_ADD:    exact = xa + xb;
            OP_SUB:    exact = xa - xb;
            OP_MUL:    exact = xa * xb;
            OP_SHA:    exact = sh_res;
            OP_ABSDIF: exact = (xa > xb) ? (xa - xb) : (xb - xa);
            default:   exact = '0;
        endcase
    end
endmodule

// File: rtl/sat_alu_clamp.sv
// Clamp stage: limits the exact result to the signed or unsigned W-bit range
// and reports whether clamping happened and the advance-overflow bit.
// Assumes the exact value is wide enough to hold every operation's result.
module sat_alu_clamp #(
    parameter int W  = 32,
    parameter int XW = 2 * W + 1
) (
    input  logic signed [XW-1:0]  exact,
    input  logic                  sat_signed,
    output logic [W-1:0]          res,
    output logic                  ovf,
    output logic                  adv
);
    localparam logic signed [XW-1:0] S_MAX = {{(XW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] S_MIN = {{(XW-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [XW-1:0] U_MAX = {{(XW-W){1'b0}}, {W{1'b1}}};
    localparam logic signed [XW-1:0] U_MIN = '0;

    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] lo;

    // Pick the bounds and compare the exact value against them.
    always_comb begin
        hi = sat_signed ? S_MAX : U_MAX;
        lo = sat_signed ? S_MIN : U_MIN;
        if (exact > hi) begin
            res = hi[W-1:0];
            ovf = 1'b1;
        end else if (exact < lo) begin
            res = lo[W-1:0];
            ovf = 1'b1;
        end else begin
            res = exact[W-1:0];
            ovf = 1'b0;
        end
        adv = exact[W-1] ^ exact[W-2];
    end
endmodule

// File: rtl/sat_alu_flags.sv
// Status flag file: for each event channel, keeps a last-operation bit and
// a sticky bit. Updates only on valid; the clear input zeroes the sticky bits
// before this cycle's event is ORed in. Synchronous active-low reset.
module sat_alu_flags #(
    parameter int NCH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            clr,
    input  logic [NCH-1:0]  evt,
    output logic [NCH-1:0]  now,
    output logic [NCH-1:0]  sticky
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Register the last event and accumulate the sticky copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                now[g]    <= 1'b0;
                sticky[g] <= 1'b0;
            end else begin
                if (valid) begin
                    now[g] <= evt[g];
                end
                sticky[g] <= (sticky[g] & ~clr) | (valid & evt[g]);
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
// Saturating ALU top: exact arithmetic, clamp, and registered flag file.
// The result is combinational from the inputs; the flags change on the
// clock edge where valid is high. Synchronous active-low reset.
module sat_alu #(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic          is_signed,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic          clr_sticky,
    output logic [W-1:0]  result,
    output logic          flag_v,
    output logic          flag_sv,
    output logic          flag_av,
    output logic          flag_sav
);
    localparam int XW  = 2 * W + 1;
    localparam int SHW = $clog2(W) + 1;

    logic signed [XW-1:0] sh_res;
    logic signed [XW-1:0] exact;
    logic                 sat_signed;
    logic                 ovf;
    logic                 adv;
    logic [1:0]           f_now;
    logic [1:0]           f_sticky;

    sat_alu_shift #(.W(W), .XW(XW), .SHW(SHW)) u_shift (
        .val (opa),
        .cnt (opb[SHW-1:0]),
        .res (sh_res)
    );

    sat_alu_core #(.W(W), .XW(XW)) u_core (
        .op         (op),
        .is_signed  (is_signed),
        .opa        (opa),
        .opb        (opb),
        .sh_res     (sh_res),
        .exact      (exact),
        .sat_signed (sat_signed)
    );

    sat_alu_clamp #(.W(W), .XW(XW)) u_clamp (
        .exact      (exact),
        .sat_signed (sat_signed),
        .res        (result),
        .ovf        (ovf),
        .adv        (adv)
    );

    sat_alu_flags #(.NCH(2)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (valid),
        .clr    (clr_sticky),
        .evt    ({adv, ovf}),
        .now    (f_now),
        .sticky (f_sticky)
    );

    // Map the flag channels to the named outputs.
    always_comb begin
        flag_v   = f_now[0];
        flag_av  = f_now[1];
        flag_sv  = f_sticky[0];
        flag_sav = f_sticky[1];
    end
endmodule

// File: rtl/sat_alu_chk.sv
// Port-level property checker for the saturating ALU, attached by bind.
// Assumes the operation code encoding of sat_alu_pkg.
module sat_alu_chk #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid,
    input logic [2:0]    op,
    input logic          clr_sticky,
    input logic [W-1:0]  result,
    input logic          flag_v,
    input logic          flag_sv,
    input logic          flag_av,
    input logic          flag_sav
);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr_sticky) |=> ($stable(flag_v) && $stable(flag_sv)
                                     && $stable(flag_av) && $stable(flag_sav)));

    // R7
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sticky && flag_sv && flag_sav) |=> (flag_sv && flag_sav));

    // R5
    ovf_to_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_v) |-> flag_sv);

    // R6
    adv_to_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_av) |-> flag_sav);

    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky && !valid) |=> (!flag_sv && !flag_sav));

    // R4
    absdif_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4) |-> !result[W-1]);

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 3'd4) |-> (result == '0));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        is_signed = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        clr_sticky = 1'b0;
    logic [31:0] result;
    logic        flag_v, flag_sv, flag_av, flag_sav;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected flag state
    logic ev = 0, esv = 0, eav = 0, esav = 0;

    always #10 clk = ~clk;

    sat_alu u_sat_alu (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .is_signed(is_signed),
        .opa(opa), .opb(opb), .clr_sticky(clr_sticky), .result(result),
        .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav)
    );

    // stimulus: {op, is_signed, opa, opb}
    localparam int NV = 23;
    localparam logic [67:0] VEC [NV] = '{
        {3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001},
        {3'd0, 1'b0, 32'h00000001, 32'h00000002},
        {3'd0, 1'b0, 32'h40000000, 32'h00000000},
        {3'd1, 1'b0, 32'h00000001, 32'h00000002},
        {3'd1, 1'b0, 32'h00000005, 32'h00000003},
        {3'd2, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd2, 1'b0, 32'h00010000, 32'h0000FFFF},
        {3'd0, 1'b1, 32'h7FFFFFFF, 32'h00000001},
        {3'd0, 1'b1, 32'h80000000, 32'hFFFFFFFF},
        {3'd1, 1'b1, 32'h80000000, 32'h00000001},
        {3'd2, 1'b1, 32'h80000000, 32'hFFFFFFFF},
        {3'd2, 1'b1, 32'hFFFFFFFE, 32'h00000003},
        {3'd3, 1'b1, 32'h00000001, 32'h0000001F},
        {3'd3, 1'b1, 32'h80000000, 32'h00000020},
        {3'd3, 1'b1, 32'h12345678, 32'h00000000},
        {3'd3, 1'b0, 32'h00000040, 32'h0000003E},
        {3'd3, 1'b1, 32'hFFFFFFFF, 32'h0000003F},
        {3'd3, 1'b0, 32'h00000001, 32'hFFFFFF01},
        {3'd4, 1'b1, 32'h80000000, 32'h7FFFFFFF},
        {3'd4, 1'b1, 32'h00000005, 32'h00000009},
        {3'd4, 1'b1, 32'h00000000, 32'h00000000},
        {3'd4, 1'b0, 32'hFFFFFFFF, 32'h00000001},
        {3'd5, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF}
    };

    // Reference: exact value in 80 bits, clamp, advance bit.
    function automatic void model(input logic [2:0] o, input logic s,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic v,
                                  output logic av);
        logic signed [79:0] x, sa, sb, za, zb, hi, lo;
        logic sg;
        int c;
        sa = {{48{a[31]}}, a};
        sb = {{48{b[31]}}, b};
        za = {48'd0, a};
        zb = {48'd0, b};
        sg = s || (o == 3'd3) || (o == 3'd4);
        case (o)
            3'd0: x = s ? sa + sb : za + zb;
            3'd1: x = s ? sa - sb : za - zb;
            3'd2: x = s ? sa * sb : za * zb;
            3'd3: begin
                c = int'($signed(b[5:0]));
                x = (c >= 0) ? (sa <<< c) : (sa >>> (-c));
            end
            3'd4: x = (sa > sb) ? sa - sb : sb - sa;
            default: x = '0;
        endcase
        hi = sg ? 80'sh7FFFFFFF : 80'shFFFFFFFF;
        lo = sg ? -80'sh80000000 : 80'sh0;
        if (x > hi) begin r = hi[31:0]; v = 1'b1; end
        else if (x < lo) begin r = lo[31:0]; v = 1'b1; end
        else begin r = x[31:0]; v = 1'b0; end
        av = x[31] ^ x[30];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string ctx);
        check(flag_v == ev, {"R5 flag_v ", ctx}, {31'd0, flag_v}, {31'd0, ev});
        check(flag_av == eav, {"R6 flag_av ", ctx}, {31'd0, flag_av}, {31'd0, eav});
        check(flag_sv == esv, {"R7 R8 flag_sv ", ctx}, {31'd0, flag_sv}, {31'd0, esv});
        check(flag_sav == esav, {"R7 R8 flag_sav ", ctx}, {31'd0, flag_sav}, {31'd0, esav});
    endtask

    // One cycle: drive after a falling edge, check result, pass the rising
    // edge, then check the flags at the next falling edge.
    task automatic step(input logic vl, input logic cl, input logic [2:0] o,
                        input logic s, input logic [31:0] a, input logic [31:0] b,
                        input string ctx);
        logic [31:0] r;
        logic v, av;
        string tag;
        valid = vl; clr_sticky = cl; op = o; is_signed = s; opa = a; opb = b;
        #2;
        model(o, s, a, b, r, v, av);
        if (o == 3'd3) tag = "R3";
        else if (o == 3'd4) tag = "R4";
        else if (o > 3'd4) tag = "R10";
        else if (s) tag = "R2";
        else tag = "R1";
        check(result == r, {tag, " result ", ctx}, result, r);
        if (!rst_n) begin
            ev = 0; esv = 0; eav = 0; esav = 0;
        end else begin
            if (cl) begin esv = 0; esav = 0; end
            if (vl) begin ev = v; eav = av; esv = esv | v; esav = esav | av; end
        end
        @(negedge clk);
        check_flags(ctx);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9: flags zero after reset
        check(!flag_v && !flag_sv && !flag_av && !flag_sav, "R9 reset state",
              {28'd0, flag_v, flag_sv, flag_av, flag_sav}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b0, VEC[i][67:65], VEC[i][64], VEC[i][63:32], VEC[i][31:0],
                 $sformatf("vec%0d", i));
        end
        // R7: idle cycle with overflowing inputs leaves flags as they are
        step(1'b1, 1'b0, 3'd0, 1'b0, 32'h40000000, 32'h0, "set av");
        step(1'b0, 1'b0, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h1, "idle hold");
        // R8: clear alone zeroes sticky, keeps last-op flags
        step(1'b0, 1'b1, 3'd0, 1'b0, 32'h0, 32'h0, "clear idle");
        // R8: clear with an overflowing op keeps that op's events
        step(1'b1, 1'b1, 3'd0, 1'b1, 32'h7FFFFFFF, 32'h1, "clear with op");
        // R5/R7: clean op clears V while SV stays
        step(1'b1, 1'b0, 3'd1, 1'b1, 32'h5, 32'h3, "clean after ovf");
        // R10: unused code with valid clears V
        step(1'b1, 1'b0, 3'd7, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, "code7");
        // R9: reset in mid-run with sticky set
        step(1'b1, 1'b0, 3'd0, 1'b1, 32'h7FFFFFFF, 32'h1, "set before reset");
        rst_n = 1'b0;
        step(1'b1, 1'b0, 3'd0, 1'b1, 32'h7FFFFFFF, 32'h1, "R9 reset");
        rst_n = 1'b1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule